// File: doc/BRIEF.md
# Multiplexed Seven-Segment Shift Driver

This block keeps a four-digit multiplexed seven-segment display lit. It drives an external serial-in, parallel-out shift register that has a storage latch. Each digit slot holds a 5-bit value. The low four bits are a glyph code and bit 4 is a decimal-point flag. A free-running refresh timer picks one digit per interval. For that digit the block builds a byte with the glyph code in the upper nibble and a one-hot digit select in the lower nibble. It shifts the byte out MSB first on a data pin and a shift clock, then pulses the latch line. Glyph decoding and segment wiring happen downstream.

Two quirks of the wiring shape the pin sequence:

- **Shared latch line.** The latch line also serves as the active-low output enable of the register. The block holds the line high for the whole shift so the display stays blank. It then drives the line low, high (the latch transfer), and low again.
- **Shared data line.** Between frames the data line carries the decimal point of the digit just shown. It idles high and is driven low when that digit's dot flag is set.

A display-enable input stops new frames while another agent rewrites the digit slots. The refresh period must be longer than one frame, which takes 18 × HALF_CLKS system clocks.

Top module: `seg_mux_driver`

## Requirements
- R1: After reset the latch line is low, the shift clock is low, the data line is high, and no frame is in progress.
- R2: The latched byte is {slot[3:0], select}. The select nibble is one-hot, with bit k set for digit index k.
- R3: Digit indices are sent in the order 0, 1, 2, 3 and then wrap to 0. Index 0 is the rightmost position.
- R4: The byte is shifted MSB first, one bit per rising edge of the shift clock. The data line is set while the shift clock is low and does not change at the rising edge.
- R5: The latch line goes high in the first cycle of a frame and stays high across all eight shift-clock rising edges.
- R6: After the eighth bit, the latch line goes low for HALF_CLKS cycles, then high for HALF_CLKS cycles (the latch transfer), then low again.
- R7: When a frame ends, the data line is driven to the inverse of that digit's dot flag: high when the flag is clear, low when it is set.
- R8: While display-enable stays high, frames start exactly REFRESH_CLKS system clocks apart.
- R9: Within a frame, successive shift-clock rising edges are 2 × HALF_CLKS system clocks apart.
- R10: While display-enable is low no frame starts. After it returns high, a frame starts at the next refresh tick, within REFRESH_CLKS cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_en | input | 1 | When high, refresh frames are allowed to start |
| digit_slots | input | 4x5 | Digit slot k: bit 4 is the dot flag, bits [3:0] are the glyph code |
| ser_data | output | 1 | Serial data during a frame; inverse of the dot flag between frames |
| shift_clk | output | 1 | Shift-register clock; data is taken on its rising edge |
| latch_oe | output | 1 | Storage-latch clock, also the active-low output enable |

## Verification
The bench models the shift register and the latch. At each latch rise that follows exactly eight shifts, it compares the latched byte with the glyph and one-hot select computed for the expected index. It sweeps every 5-bit value through every slot, so a reversed bit order, a wrong select bit or a skipped index shows up as a byte mismatch. Every shift-clock rise taken while the latch line is low is reported, which catches a design that enables the outputs mid-shift. The bench also checks the data-line level after each frame, the spacing between frame starts, and the clock phases. A design that latches a stale dot, drifts its refresh period or refreshes while disabled fails one of these checks.

// File: rtl/seg_mux_pkg.sv
package seg_mux_pkg;
  localparam int NUM_SLOTS = 4;
  localparam int SLOT_W    = 5;
  localparam int IDX_W     = $clog2(NUM_SLOTS);
  localparam int FRAME_W   = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BIT_LO,
    ST_BIT_HI,
    ST_LAT_LO,
    ST_LAT_HI
  } seq_state_t;

  // Glyph code in the upper nibble, one-hot slot select in the lower nibble.
  function automatic logic [FRAME_W-1:0] frame_byte(input logic [IDX_W-1:0] idx,
                                                     input logic [SLOT_W-1:0] slot);
    logic [3:0] sel;
    sel = 4'b0001 << idx;
    return {slot[3:0], sel};
  endfunction
endpackage

// File: rtl/refresh_timer.sv
module refresh_timer #(
  parameter int PERIOD = 75000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  // R8
  tick_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == '0));
endmodule

// File: rtl/digit_selector.sv
module digit_selector import seg_mux_pkg::*; (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               advance,
  input  logic [NUM_SLOTS-1:0][SLOT_W-1:0]   digit_slots,
  output logic [IDX_W-1:0]                   idx,
  output logic [SLOT_W-1:0]                  slot
);
  always_ff @(posedge clk) begin
    if (!rst_n)       idx <= '0;
    else if (advance) idx <= idx + 1'b1;
  end

  assign slot = digit_slots[idx];

  // R3
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (idx == IDX_W'($past(idx) + 1)));

  // R3
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(idx));
endmodule

// File: rtl/shift_sequencer.sv
module shift_sequencer import seg_mux_pkg::*; #(
  parameter int HALF_CLKS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame,
  input  logic               dot,
  output logic               ser_data,
  output logic               shift_clk,
  output logic               latch_oe,
  output logic               frame_done,
  output logic               idle
);
  localparam int PW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
  localparam int BW = $clog2(FRAME_W);

  seq_state_t         state;
  logic [PW-1:0]      ph;
  logic [BW-1:0]      bitn;
  logic [FRAME_W-1:0] shreg;
  logic               dot_q;
  logic               ph_end;

  assign ph_end = (ph == PW'(HALF_CLKS - 1));
  assign idle   = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      ph         <= '0;
      bitn       <= '0;
      shreg      <= '0;
      dot_q      <= 1'b0;
      ser_data   <= 1'b1;
      shift_clk  <= 1'b0;
      latch_oe   <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      ph         <= ph_end ? '0 : ph + 1'b1;
      case (state)
        ST_IDLE: begin
          ph <= '0;
          if (start) begin
            latch_oe  <= 1'b1;
            shreg     <= frame;
            dot_q     <= dot;
            ser_data  <= frame[FRAME_W-1];
            shift_clk <= 1'b0;
            bitn      <= '0;
            state     <= ST_BIT_LO;
          end
        end
        ST_BIT_LO: if (ph_end) begin
          shift_clk <= 1'b1;
          state     <= ST_BIT_HI;
        end
        ST_BIT_HI: if (ph_end) begin
          shift_clk <= 1'b0;
          if (bitn == BW'(FRAME_W - 1)) begin
            latch_oe <= 1'b0;
            state    <= ST_LAT_LO;
          end else begin
            shreg    <= shreg << 1;
            ser_data <= shreg[FRAME_W-2];
            bitn     <= bitn + 1'b1;
            state    <= ST_BIT_LO;
          end
        end
        ST_LAT_LO: if (ph_end) begin
          latch_oe <= 1'b1;
          state    <= ST_LAT_HI;
        end
        ST_LAT_HI: if (ph_end) begin
          latch_oe   <= 1'b0;
          ser_data   <= ~dot_q;
          frame_done <= 1'b1;
          state      <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5
  shift_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shift_clk) |-> latch_oe);

  // R4
  data_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shift_clk) |-> $stable(ser_data));

  // R7
  idle_dot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (ser_data == !dot_q) && !latch_oe);

  // R2
  load_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && idle) |=> ($countones(shreg[3:0]) == 1) && latch_oe);
endmodule

// File: rtl/seg_mux_driver.sv
module seg_mux_driver import seg_mux_pkg::*; #(
  parameter int REFRESH_CLKS = 75000,
  parameter int HALF_CLKS    = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            disp_en,
  input  logic [3:0][4:0] digit_slots,
  output logic            ser_data,
  output logic            shift_clk,
  output logic            latch_oe
);
  logic               refresh_tick;
  logic               frame_start;
  logic               frame_done;
  logic               seq_idle;
  logic [IDX_W-1:0]   cur_idx;
  logic [SLOT_W-1:0]  cur_slot;
  logic [FRAME_W-1:0] cur_frame;

  refresh_timer #(.PERIOD(REFRESH_CLKS)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (refresh_tick)
  );

  digit_selector u_sel (
    .clk         (clk),
    .rst_n       (rst_n),
    .advance     (frame_done),
    .digit_slots (digit_slots),
    .idx         (cur_idx),
    .slot        (cur_slot)
  );

  assign frame_start = refresh_tick & disp_en & seq_idle;
  assign cur_frame   = frame_byte(cur_idx, cur_slot);

  shift_sequencer #(.HALF_CLKS(HALF_CLKS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (frame_start),
    .frame      (cur_frame),
    .dot        (cur_slot[4]),
    .ser_data   (ser_data),
    .shift_clk  (shift_clk),
    .latch_oe   (latch_oe),
    .frame_done (frame_done),
    .idle       (seq_idle)
  );

  // R10
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!disp_en && seq_idle) |=> seq_idle && !latch_oe);

  // R1
  reset_pins_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> (!latch_oe && !shift_clk && ser_data));
endmodule

// File: tb/seg_mux_driver_tb.sv
module seg_mux_driver_tb;
  localparam int REFRESH = 48;
  localparam int HALF    = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            disp_en = 1'b0;
  logic [3:0][4:0] digit_slots = '0;
  logic            ser_data, shift_clk, latch_oe;

  int n_checks = 0;
  int n_errors = 0;
  int cyc = 0;
  int frames = 0;
  int starts = 0;

  seg_mux_driver #(.REFRESH_CLKS(REFRESH), .HALF_CLKS(HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .disp_en(disp_en), .digit_slots(digit_slots),
    .ser_data(ser_data), .shift_clk(shift_clk), .latch_oe(latch_oe)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Model of the external shift register and storage latch.
  logic       prev_sck = 1'b0, prev_le = 1'b0;
  logic [7:0] model_sr = '0;
  int         bits = 0;
  int         exp_idx = 0;
  int         exp_byte = 0;
  bit         exp_dot = 1'b0;
  bit         pend_end = 1'b0;
  int         last_rise = -1;
  int         last_start = -1;
  bit         gap_ok = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (shift_clk && !prev_sck) begin
        // R5: outputs must stay blanked at every shift edge
        check(latch_oe == 1'b1, "R5 latch high at shift edge", latch_oe, 1);
        // R9: shift clock period within a frame
        if (bits > 0)
          check(cyc - last_rise == 2 * HALF, "R9 shift edge spacing", cyc - last_rise, 2 * HALF);
        last_rise = cyc;
        model_sr = {model_sr[6:0], ser_data};
        bits++;
      end
      if (latch_oe && !prev_le) begin
        if (bits == 8) begin
          // R2 R3 R4 R6: byte in the latch after the transfer pulse
          check(model_sr == 8'(exp_byte), "R2/R3/R4/R6 latched byte", model_sr, exp_byte);
          pend_end = 1'b1;
        end else begin
          check(bits == 0, "R6 latch pulse only at frame start or after 8 bits", bits, 0);
          starts++;
          // R8: refresh spacing
          if (gap_ok && last_start >= 0)
            check(cyc - last_start == REFRESH, "R8 frame spacing", cyc - last_start, REFRESH);
          last_start = cyc;
          gap_ok = 1'b1;
          exp_byte = int'(digit_slots[exp_idx][3:0]) * 16 + (1 << exp_idx);
          exp_dot = digit_slots[exp_idx][4];
        end
        bits = 0;
      end
      if (!latch_oe && prev_le && pend_end) begin
        // R7: data line carries the inverted dot flag after the frame
        check(ser_data == !exp_dot, "R7 idle data level", ser_data, !exp_dot);
        pend_end = 1'b0;
        exp_idx = (exp_idx + 1) % 4;
        frames++;
      end
    end
    prev_sck = shift_clk;
    prev_le  = latch_oe;
  end

  task automatic wait_frames(input int n);
    int target;
    target = frames + n;
    while (frames < target) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle pins after reset
    check(latch_oe == 1'b0, "R1 latch low", latch_oe, 0);
    check(shift_clk == 1'b0, "R1 shift clock low", shift_clk, 0);
    check(ser_data == 1'b1, "R1 data high", ser_data, 1);
    repeat (2 * REFRESH) @(negedge clk);
    check(starts == 0, "R10 no frame while disabled from reset", starts, 0);

    disp_en = 1'b1;
    // Sweep every slot value through every index (R2, R3, R4, R7).
    for (int v = 0; v < 32; v++) begin
      for (int k = 0; k < 4; k++) digit_slots[k] = 5'((v + 7 * k) % 32);
      wait_frames(4);
    end

    // R10: disable between frames; nothing may start
    begin
      int s0;
      int t0;
      disp_en = 1'b0;
      gap_ok = 1'b0;
      s0 = starts;
      repeat (3 * REFRESH) @(negedge clk);
      check(starts == s0, "R10 frames while disabled", starts - s0, 0);
      for (int k = 0; k < 4; k++) digit_slots[k] = 5'(5'h10 | (k * 3));
      disp_en = 1'b1;
      t0 = cyc;
      while (starts == s0 && cyc - t0 <= REFRESH + 2) @(negedge clk);
      check(starts == s0 + 1, "R10 frame resumes within one interval", starts - s0, 1);
      wait_frames(8);
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    while (cyc < 150000) @(negedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule